// File: doc/BRIEF.md
# Test Pin Selector with Bypass Dividers

This block picks what a clock synthesizer shows on its single test pin, and it holds the post divider and the M feedback counter that normally sit behind the PLL. A 3-bit select code chooses one of eight test sources: the captured serial data bit, two fixed levels, the reference clock divided by sixteen, the M-counter pulse, the synthesized clock, that clock divided by four, and a bypass setting. In bypass, the serial shift clock drives the M counter and the post divider directly, so low-speed board tests can step the clock tree from a slow, controllable source. The PLL itself is not modelled: a stand-in input carries the synthesized clock.

All logic runs on one fast system clock. The reference, synthesized and shift clocks arrive as plain inputs. They are registered and turned into one-cycle rising-edge strobes, so every divider is an edge counter in the system domain and every output is a flop. Changes to the divide code and to the select code take effect only at safe points, so neither output can produce a shortened pulse.

Top module: `testpin_mux_div`

## Requirements
- R1: While reset is high, and in the first cycle after it, `fout_o` and `test_o` are 0 and the active selection is the serial-data code 000.
- R2: The main output toggles once every R rising edges of its source, so its period is 2·R source periods. R is 1, 2, 4 and 8 for `n_i` = 00, 01, 10 and 11. Outside bypass the source is the synthesized clock.
- R3: With select 000, the test pin shows the value of `sh_data_i` taken at each rising edge of the shift clock. It does not change between shift-clock edges.
- R4: Select 001 holds the test pin at 1 and select 101 holds it at 0.
- R5: Select 010 drives the test pin with a square wave of 16 reference-clock periods, high for 8.
- R6: Select 011 drives the test pin with the M-counter pulse, which is high for one source period once every M source periods. An `m_i` of 0 counts as 1, so M of 0 or 1 holds the pin high.
- R7: Select 100 drives the test pin with the synthesized-clock level. Select 111 drives it with a square wave of 4 synthesized-clock periods, high for 2.
- R8: Select 110 is bypass. The shift clock becomes the source of both the post divider and the M counter, and the test pin shows the M-counter pulse.
- R9: A new `n_i` is taken only when the main output toggles. The half period already in progress always completes at its old length.
- R10: A new select code is taken only while the test pin is low, or at once if the current code is a fixed level. After a switch to a non-fixed code, the pin stays low until the new source is low, so its first high pulse is full length.
- R11: The M counter takes a new `m_i` only at its terminal count. The period in progress when `m_i` changes keeps the old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state is updated on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | 1 | Reference clock, sampled by the system clock |
| syn_clk_i | input | 1 | Stand-in for the synthesized clock |
| sh_clk_i | input | 1 | Serial shift clock |
| sh_data_i | input | 1 | Serial output of the configuration shift register |
| m_i | input | 9 | M-counter modulus |
| n_i | input | 2 | Post-divider code |
| t_i | input | 3 | Test-pin select code |
| fout_o | output | 1 | Divided main clock |
| test_o | output | 1 | Test pin |

## Verification
The bench goes after the switching points. It changes the divide code three cycles into a 16-cycle high half and requires that half to finish at 16 cycles; a design that applied the code at once would cut the half short or let the counter run past its new limit. It changes `m_i` at the start of an M period and requires one more period at the old length, which catches a counter that reloads as soon as the input changes. It switches the select code away while the reference-divided wave is high and requires the full 32-cycle high to survive, then switches into the divide-by-four wave and requires its first high to be full. A design without the deferred switch would shorten that pulse. Fixed levels, M of 1, the serial bit frozen between shift edges, and bypass periods taken from a slow shift clock cover the remaining select codes.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

    localparam int N_W    = 2;
    localparam int T_W    = 3;
    localparam int HALF_W = 2 ** N_W;

    localparam int SRC_REF = 0;
    localparam int SRC_SYN = 1;
    localparam int SRC_SH  = 2;
    localparam int NUM_SRC = 3;

    typedef enum logic [T_W-1:0] {
        TS_SHIFT  = 3'b000,
        TS_ONE    = 3'b001,
        TS_REFDIV = 3'b010,
        TS_MCNT   = 3'b011,
        TS_SYNTH  = 3'b100,
        TS_ZERO   = 3'b101,
        TS_BYPASS = 3'b110,
        TS_SYNDIV = 3'b111
    } tpm_code_e;

    // Source edges per half period of the main output for a divide code.
    function automatic logic [HALF_W-1:0] ndiv_half(input logic [N_W-1:0] code);
        return HALF_W'(1) << code;
    endfunction

    // Fixed-level selections carry no edges and may be left at any time.
    function automatic logic is_static(input tpm_code_e c);
        return (c == TS_ONE) || (c == TS_ZERO);
    endfunction

endpackage

// File: rtl/tpm_edge.sv
module tpm_edge (
    input  logic clk,
    input  logic rst,
    input  logic in_i,
    output logic rise_o
);
    logic cur_q;
    logic prv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= 1'b0;
            prv_q <= 1'b0;
        end else begin
            cur_q <= in_i;
            prv_q <= cur_q;
        end
    end

    assign rise_o = cur_q & ~prv_q;

endmodule

// File: rtl/tpm_tog_div.sv
module tpm_tog_div #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_i,
    input  logic [CNT_W-1:0] half_i,
    output logic             q_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cur_half_q;
    logic             q_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            cur_half_q <= half_i;
            q_q        <= 1'b0;
        end else if (rise_i) begin
            if (cnt_q == cur_half_q - CNT_W'(1)) begin
                cnt_q      <= '0;
                q_q        <= ~q_q;
                cur_half_q <= half_i;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign q_o = q_q;

    AST_TOGGLE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        !$stable(q_q) |-> $past(rise_i));                         // R2
    AST_HALF_AT_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_half_q) |-> !$stable(q_q));                  // R9

endmodule

// File: rtl/tpm_mcount.sv
module tpm_mcount #(
    parameter int M_W = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rise_i,
    input  logic [M_W-1:0] m_i,
    output logic           pulse_o
);
    logic [M_W-1:0] cnt_q;
    logic [M_W-1:0] eff_m;
    logic           pulse_q;

    assign eff_m = (m_i == '0) ? M_W'(1) : m_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else if (rise_i) begin
            if (cnt_q == '0) begin
                cnt_q   <= eff_m - M_W'(1);
                pulse_q <= 1'b1;
            end else begin
                cnt_q   <= cnt_q - M_W'(1);
                pulse_q <= 1'b0;
            end
        end
    end

    assign pulse_o = pulse_q;

    AST_COUNT_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_q) |-> $past(rise_i));                       // R6
    AST_PULSE_TERMINAL: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_q) |-> $past(cnt_q) == '0);                   // R11

endmodule

// File: rtl/tpm_test_mux.sv
module tpm_test_mux
    import tpm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [T_W-1:0]      t_i,
    input  logic [2**T_W-1:0]   src_i,
    output tpm_code_e           t_act_o,
    output logic                test_o
);
    tpm_code_e t_act_q;
    tpm_code_e t_req;
    tpm_code_e t_nxt;
    logic      hold_q;
    logic      hold_nxt;
    logic      test_q;

    assign t_req = tpm_code_e'(t_i);

    always_comb begin
        t_nxt    = t_act_q;
        hold_nxt = hold_q;
        if (t_req != t_act_q && (!test_q || is_static(t_act_q))) begin
            t_nxt    = t_req;
            hold_nxt = !is_static(t_req);
        end else if (hold_q && !src_i[t_act_q]) begin
            hold_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_act_q <= TS_SHIFT;
            hold_q  <= 1'b0;
            test_q  <= 1'b0;
        end else begin
            t_act_q <= t_nxt;
            hold_q  <= hold_nxt;
            test_q  <= hold_nxt ? 1'b0 : src_i[t_nxt];
        end
    end

    assign t_act_o = t_act_q;
    assign test_o  = test_q;

    AST_ONE_HIGH: assert property (@(posedge clk) disable iff (rst)
        t_act_q == TS_ONE |-> test_q);                            // R4
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
        t_act_q == TS_ZERO |-> !test_q);                          // R4
    AST_SWITCH_CLEAN: assert property (@(posedge clk) disable iff (rst)
        !$stable(t_act_q) |-> (!$past(test_q) || is_static($past(t_act_q)))); // R10
    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
        hold_q |-> !test_q);                                      // R10

endmodule

// File: rtl/testpin_mux_div.sv
module testpin_mux_div
    import tpm_pkg::*;
#(
    parameter int M_W     = 9,
    parameter int REF_DIV = 16,
    parameter int SYN_DIV = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ref_clk_i,
    input  logic           syn_clk_i,
    input  logic           sh_clk_i,
    input  logic           sh_data_i,
    input  logic [M_W-1:0] m_i,
    input  logic [1:0]     n_i,
    input  logic [2:0]     t_i,
    output logic           fout_o,
    output logic           test_o
);
    localparam int REF_HALF = REF_DIV / 2;
    localparam int SYN_HALF = SYN_DIV / 2;
    localparam int REF_W    = $clog2(REF_HALF) + 1;
    localparam int SYN_W    = $clog2(SYN_HALF) + 1;
    localparam int NSEL     = 2 ** T_W;

    logic [NUM_SRC-1:0] raw_clk;
    logic [NUM_SRC-1:0] rise;
    logic               syn_lvl_q;
    logic               ser_q;
    logic               bypass;
    logic               main_rise;
    logic               ref_div;
    logic               syn_div;
    logic               m_pulse;
    logic [NSEL-1:0]    src;
    tpm_code_e          t_act;

    assign raw_clk[SRC_REF] = ref_clk_i;
    assign raw_clk[SRC_SYN] = syn_clk_i;
    assign raw_clk[SRC_SH]  = sh_clk_i;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_edge
        tpm_edge u_edge (
            .clk    (clk),
            .rst    (rst),
            .in_i   (raw_clk[g]),
            .rise_o (rise[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            syn_lvl_q <= 1'b0;
            ser_q     <= 1'b0;
        end else begin
            syn_lvl_q <= syn_clk_i;
            if (rise[SRC_SH]) begin
                ser_q <= sh_data_i;
            end
        end
    end

    assign bypass    = (t_act == TS_BYPASS);
    assign main_rise = bypass ? rise[SRC_SH] : rise[SRC_SYN];

    tpm_tog_div #(.CNT_W(HALF_W)) u_post_div (
        .clk    (clk),
        .rst    (rst),
        .rise_i (main_rise),
        .half_i (ndiv_half(n_i)),
        .q_o    (fout_o)
    );

    tpm_tog_div #(.CNT_W(REF_W)) u_ref_div (
        .clk    (clk),
        .rst    (rst),
        .rise_i (rise[SRC_REF]),
        .half_i (REF_W'(REF_HALF)),
        .q_o    (ref_div)
    );

    tpm_tog_div #(.CNT_W(SYN_W)) u_syn_div (
        .clk    (clk),
        .rst    (rst),
        .rise_i (rise[SRC_SYN]),
        .half_i (SYN_W'(SYN_HALF)),
        .q_o    (syn_div)
    );

    tpm_mcount #(.M_W(M_W)) u_mcount (
        .clk     (clk),
        .rst     (rst),
        .rise_i  (main_rise),
        .m_i     (m_i),
        .pulse_o (m_pulse)
    );

    always_comb begin
        src                 = '0;
        src[int'(TS_SHIFT)]  = ser_q;
        src[int'(TS_ONE)]    = 1'b1;
        src[int'(TS_REFDIV)] = ref_div;
        src[int'(TS_MCNT)]   = m_pulse;
        src[int'(TS_SYNTH)]  = syn_lvl_q;
        src[int'(TS_ZERO)]   = 1'b0;
        src[int'(TS_BYPASS)] = m_pulse;
        src[int'(TS_SYNDIV)] = syn_div;
    end

    tpm_test_mux u_test_mux (
        .clk     (clk),
        .rst     (rst),
        .t_i     (t_i),
        .src_i   (src),
        .t_act_o (t_act),
        .test_o  (test_o)
    );

    AST_SERIAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(ser_q) |-> $past(rise[SRC_SH]));                 // R3
    AST_BYPASS_SRC: assert property (@(posedge clk) disable iff (rst)
        ($past(bypass) && !$stable(fout_o)) |-> $past(rise[SRC_SH])); // R8

endmodule

// File: tb/testpin_mux_div_bench.sv
module testpin_mux_div_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_clk_i = 1'b0;
    logic       syn_clk_i = 1'b0;
    logic       sh_gen = 1'b0;
    logic       sh_man = 1'b0;
    logic       sh_run = 1'b1;
    logic       sh_data_i = 1'b0;
    logic [8:0] m_i = 9'd5;
    logic [1:0] n_i = 2'd0;
    logic [2:0] t_i = 3'b000;
    logic       sh_clk_i;
    logic       fout_o;
    logic       test_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    assign sh_clk_i = sh_gen | sh_man;

    always #10 clk = ~clk;

    testpin_mux_div u_testpin_mux_div (
        .clk       (clk),
        .rst       (rst),
        .ref_clk_i (ref_clk_i),
        .syn_clk_i (syn_clk_i),
        .sh_clk_i  (sh_clk_i),
        .sh_data_i (sh_data_i),
        .m_i       (m_i),
        .n_i       (n_i),
        .t_i       (t_i),
        .fout_o    (fout_o),
        .test_o    (test_o)
    );

    // Source clocks: synthesized period 2 cycles, reference 4, shift 6.
    initial forever begin @(negedge clk); syn_clk_i = ~syn_clk_i; end
    initial forever begin repeat (2) @(negedge clk); ref_clk_i = ~ref_clk_i; end
    initial forever begin
        repeat (3) @(negedge clk);
        if (sh_run) sh_gen = ~sh_gen;
        else        sh_gen = 1'b0;
    end

    // {req[34:31], t[30:28], n[27:26], m[25:17], sel[16], period[15:8], high[7:0]}
    localparam int NVEC = 12;
    localparam logic [34:0] VEC [NVEC] = '{
        {4'd2, 3'b100, 2'd0, 9'd5, 1'b0, 8'd4,  8'd2},   // R2 n=00
        {4'd2, 3'b100, 2'd1, 9'd5, 1'b0, 8'd8,  8'd4},   // R2 n=01
        {4'd2, 3'b100, 2'd2, 9'd5, 1'b0, 8'd16, 8'd8},   // R2 n=10
        {4'd2, 3'b100, 2'd3, 9'd5, 1'b0, 8'd32, 8'd16},  // R2 n=11
        {4'd7, 3'b111, 2'd0, 9'd5, 1'b1, 8'd8,  8'd4},   // R7 synth/4
        {4'd7, 3'b100, 2'd0, 9'd5, 1'b1, 8'd2,  8'd1},   // R7 synth level
        {4'd5, 3'b010, 2'd0, 9'd5, 1'b1, 8'd64, 8'd32},  // R5 ref/16
        {4'd6, 3'b011, 2'd0, 9'd5, 1'b1, 8'd10, 8'd2},   // R6 M=5
        {4'd6, 3'b011, 2'd0, 9'd7, 1'b1, 8'd14, 8'd2},   // R6 M=7
        {4'd8, 3'b110, 2'd1, 9'd3, 1'b0, 8'd24, 8'd12},  // R8 bypass fout
        {4'd8, 3'b110, 2'd1, 9'd3, 1'b1, 8'd18, 8'd6},   // R8 bypass M pulse
        {4'd8, 3'b110, 2'd0, 9'd3, 1'b0, 8'd12, 8'd6}    // R8 bypass n=00
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic pick(input bit sel);
        return sel ? test_o : fout_o;
    endfunction

    // From the next 0->1 transition: cycles high, then cycles to the following rise.
    task automatic measure(input bit sel, output int per, output int hi);
        int k = 0;
        int lo = 0;
        hi = 0;
        while (pick(sel) !== 1'b0 && k < 4000) begin @(negedge clk); k++; end
        while (pick(sel) !== 1'b1 && k < 4000) begin @(negedge clk); k++; end
        while (pick(sel) === 1'b1 && k < 4000) begin hi++; @(negedge clk); k++; end
        while (pick(sel) === 1'b0 && k < 4000) begin lo++; @(negedge clk); k++; end
        per = (k >= 4000) ? 0 : hi + lo;
    endtask

    task automatic wait_rise(input bit sel);
        int k = 0;
        while (pick(sel) !== 1'b0 && k < 4000) begin @(negedge clk); k++; end
        while (pick(sel) !== 1'b1 && k < 4000) begin @(negedge clk); k++; end
    endtask

    task automatic rise_to_rise(output int c);
        c = 0;
        while (test_o === 1'b1 && c < 4000) begin @(negedge clk); c++; end
        while (test_o === 1'b0 && c < 4000) begin @(negedge clk); c++; end
    endtask

    task automatic shift_pulse();
        sh_man = 1'b1;
        wait_cyc(2);
        sh_man = 1'b0;
        wait_cyc(4);
    endtask

    initial begin
        int per;
        int hi;
        int cnt;
        @(negedge clk);
        wait_cyc(4);
        // R1: outputs low while reset is asserted
        check("R1", "fout in reset", int'(fout_o), 0);
        check("R1", "test in reset", int'(test_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "fout after reset", int'(fout_o), 0);
        check("R1", "test after reset", int'(test_o), 0);

        for (int i = 0; i < NVEC; i++) begin
            t_i = VEC[i][30:28];
            n_i = VEC[i][27:26];
            m_i = VEC[i][25:17];
            wait_cyc(300);
            measure(VEC[i][16], per, hi);
            check($sformatf("R%0d", VEC[i][34:31]), $sformatf("vector %0d period", i),
                  per, int'(VEC[i][15:8]));
            check($sformatf("R%0d", VEC[i][34:31]), $sformatf("vector %0d high", i),
                  hi, int'(VEC[i][7:0]));
        end

        // R11: M change mid-period keeps the old period once
        t_i = 3'b011; n_i = 2'd0; m_i = 9'd5;
        wait_cyc(300);
        wait_rise(1'b1);
        m_i = 9'd3;
        rise_to_rise(cnt);
        check("R11", "period after M change", cnt, 10);
        rise_to_rise(cnt);
        check("R11", "following period", cnt, 6);

        // R6: M of 1 holds the pin high
        m_i = 9'd1;
        wait_cyc(100);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); cnt += int'(test_o); end
        check("R6", "M=1 high cycles", cnt, 40);

        // R9: N change inside a high half finishes that half at the old length
        m_i = 9'd5; n_i = 2'd3;
        wait_cyc(300);
        wait_rise(1'b0);
        hi = 0;
        cnt = 0;
        while (fout_o === 1'b1 && cnt < 200) begin
            hi++;
            if (hi == 3) n_i = 2'd0;
            @(negedge clk);
            cnt++;
        end
        check("R9", "half period at change", hi, 16);
        measure(1'b0, per, hi);
        check("R9", "period after change", per, 4);

        // R10: leaving the ref/16 wave while high keeps the full high
        t_i = 3'b010;
        wait_cyc(300);
        wait_rise(1'b1);
        hi = 0;
        cnt = 0;
        while (test_o === 1'b1 && cnt < 400) begin
            hi++;
            if (hi == 5) t_i = 3'b101;
            @(negedge clk);
            cnt++;
        end
        check("R10", "high before switch", hi, 32);
        wait_cyc(5);
        cnt = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); cnt += int'(test_o); end
        check("R10", "zero after switch", cnt, 0);
        t_i = 3'b111;
        measure(1'b1, per, hi);
        check("R10", "first high after switch", hi, 4);

        // R4: fixed levels
        t_i = 3'b001;
        wait_cyc(100);
        cnt = 0;
        for (int i = 0; i < 50; i++) begin @(negedge clk); cnt += int'(test_o); end
        check("R4", "code 001 high cycles", cnt, 50);
        t_i = 3'b101;
        wait_cyc(10);
        cnt = 0;
        for (int i = 0; i < 50; i++) begin @(negedge clk); cnt += int'(test_o); end
        check("R4", "code 101 high cycles", cnt, 0);

        // R3: serial bit follows shift-clock edges only
        sh_data_i = 1'b0;
        wait_cyc(20);
        sh_run = 1'b0;
        wait_cyc(10);
        t_i = 3'b000;
        wait_cyc(10);
        sh_data_i = 1'b1;
        wait_cyc(10);
        check("R3", "no shift edge", int'(test_o), 0);
        shift_pulse();
        check("R3", "after shift edge", int'(test_o), 1);
        sh_data_i = 1'b0;
        wait_cyc(10);
        check("R3", "data change without edge", int'(test_o), 1);
        shift_pulse();
        check("R3", "after second edge", int'(test_o), 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule